// File: doc/BRIEF.md
# Dual-Bank Staggered PWM Generator

This block drives sixteen LED channels, split into two banks of eight, with pulse-width-modulated enable signals. Each channel owns a 10-bit duty register. A single commit strobe from the serial control port writes one channel in each bank at the same time: a 3-bit channel select picks the slot, and each bank takes its own 10-bit value. New values are staged and only become active when the shared counter wraps. This keeps a partly finished period from producing a truncated or stretched pulse.

A single 10-bit counter serves all channels. It advances on a PWM tick. A prescaler produces that tick from the shift clock and divides by one more than a 4-bit code. Each channel adds a fixed phase offset to the counter before it compares against its duty word. This spreads the turn-on edges across the period, so the banks do not all switch on the same clock. A force-off input, driven by fault logic, blanks every output and leaves the stored duty values intact.

Top module: `led_pwm_dual_bank`

## Requirements
- R1: A cycle with `commit` high writes `duty_a` into the staged register of bank A channel `sel_addr`. The staged values of the other seven bank A channels are unchanged.
- R2: The same commit writes `duty_b` into the staged register of bank B channel `sel_addr`. Bank B channel k drives `en_b[k]`, and bank A channel k drives `en_a[k]`.
- R3: A channel is on when its phase is less than or equal to its active duty word, and off when the phase is greater. Over one full period, a channel is on for duty+1 counts: duty 1023 is always on, and duty 0 is on for exactly one count.
- R4: With divisor code D (0 to 15), the shared counter advances once every D+1 clock cycles. The period is therefore 1024*(D+1) cycles.
- R5: The phase of a channel is (counter + 64*g) mod 1024. Here g = k for bank A channel k and g = 8+k for bank B channel k. With equal duty words, no two channels turn on in the same cycle.
- R6: Staged values are copied into the active registers only on the tick that takes the counter from 1023 to 0. A commit issued in the middle of a period leaves that period's output unchanged.
- R7: While reset is asserted, all outputs are 0. The counter, the prescaler and every duty register are cleared. In the first cycle after release, only `en_a[0]` is on.
- R8: When `force_off` is high in a cycle, all sixteen outputs are 0 in the next cycle. Duty registers keep their values, and output resumes with the stored duty words once the input is released.
- R9: Each output is a register that reflects the counter, active duty and `force_off` values of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; source of the PWM tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit | input | 1 | One-cycle strobe that writes both banks |
| sel_addr | input | 3 | Channel slot written in each bank |
| duty_a | input | 10 | Duty word for bank A |
| duty_b | input | 10 | Duty word for bank B |
| div_code | input | 4 | Prescaler code; tick every code+1 cycles |
| force_off | input | 1 | Blank all outputs while high |
| en_a | output | 8 | Bank A channel enables |
| en_b | output | 8 | Bank B channel enables |

## Verification
The bench builds the block with its default parameters: eight channels per bank, 10-bit duty words, a 64-count stagger step and a 4-bit divisor. With these values, a full 1024-count period at divisor 0 lasts only 1024 cycles. This leaves room to measure whole periods for duty extremes, stagger spacing and the wrap-aligned update, and also to cover the slowest divisor code 15 in one 16384-cycle window. A cycle-level model in the bench follows random commits, divisor changes and force-off pulses, and is compared against every output on every cycle.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

  // Phase seen by a channel: shared count plus its fixed offset, modulo 2^width.
  function automatic int unsigned stagger_phase(int unsigned count,
                                                int unsigned chan_idx,
                                                int unsigned step,
                                                int unsigned width);
    int unsigned mask;
    mask = (32'd1 << width) - 32'd1;
    return (count + chan_idx * step) & mask;
  endfunction

  // A channel conducts while its phase has not passed its duty word.
  function automatic logic duty_active(int unsigned phase, int unsigned duty);
    return phase <= duty;
  endfunction

  // Prescaler finishes its run once the running count reaches the code.
  function automatic logic prescale_done(int unsigned pre, int unsigned code);
    return pre >= code;
  endfunction

endpackage

// File: rtl/led_pwm_prescaler.sv
module led_pwm_prescaler #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick
);

  logic [DIV_W-1:0] pre_q;

  // ">=" rather than "==" so a code lowered mid-run cannot strand the count.
  assign tick = led_pwm_pkg::prescale_done(32'(pre_q), 32'(div_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/led_pwm_timebase.sv
module led_pwm_timebase #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign wrap = tick && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/led_pwm_duty_bank.sv
module led_pwm_duty_bank #(
  parameter int CH     = 8,
  parameter int DUTY_W = 10,
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [ADDR_W-1:0]      sel_addr,
  input  logic [DUTY_W-1:0]      din,
  input  logic                   wrap,
  output logic [CH*DUTY_W-1:0]   pend_flat,
  output logic [CH*DUTY_W-1:0]   act_flat
);

  for (genvar c = 0; c < CH; c++) begin : g_slot
    logic [DUTY_W-1:0] pend_q;
    logic [DUTY_W-1:0] act_q;
    logic              hit;

    assign hit = commit && (sel_addr == ADDR_W'(c));

    // Staged copy takes writes at any time.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend_q <= '0;
      else if (hit) pend_q <= din;
    end

    // Active copy moves only on the period boundary.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_q <= '0;
      else if (wrap) act_q <= pend_q;
    end

    assign pend_flat[c*DUTY_W +: DUTY_W] = pend_q;
    assign act_flat[c*DUTY_W +: DUTY_W]  = act_q;
  end

endmodule

// File: rtl/led_pwm_channel.sv
module led_pwm_channel #(
  parameter int DUTY_W = 10,
  parameter int IDX    = 0,
  parameter int STEP   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] cnt,
  input  logic [DUTY_W-1:0] duty,
  input  logic              force_off,
  output logic              en
);

  logic [31:0] phase32;
  logic        on_now;

  assign phase32 = led_pwm_pkg::stagger_phase(32'(cnt), IDX, STEP, DUTY_W);
  assign on_now  = !force_off && led_pwm_pkg::duty_active(phase32, 32'(duty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= on_now;
  end

endmodule

// File: rtl/led_pwm_dual_bank.sv
module led_pwm_dual_bank #(
  parameter int CH_PER_BANK  = 8,
  parameter int DUTY_W       = 10,
  parameter int DIV_W        = 4,
  parameter int STAGGER_STEP = 64,
  localparam int ADDR_W      = (CH_PER_BANK > 1) ? $clog2(CH_PER_BANK) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [ADDR_W-1:0]      sel_addr,
  input  logic [DUTY_W-1:0]      duty_a,
  input  logic [DUTY_W-1:0]      duty_b,
  input  logic [DIV_W-1:0]       div_code,
  input  logic                   force_off,
  output logic [CH_PER_BANK-1:0] en_a,
  output logic [CH_PER_BANK-1:0] en_b
);

  localparam int FLAT_W = CH_PER_BANK * DUTY_W;

  // Internal events brought out by name for the checker.
  logic              tick;
  logic              wrap;
  logic [DUTY_W-1:0] cnt;
  logic [FLAT_W-1:0] pend_a_flat;
  logic [FLAT_W-1:0] pend_b_flat;
  logic [FLAT_W-1:0] act_a_flat;
  logic [FLAT_W-1:0] act_b_flat;

  led_pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_code (div_code),
    .tick     (tick)
  );

  led_pwm_timebase #(.CNT_W(DUTY_W)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  led_pwm_duty_bank #(.CH(CH_PER_BANK), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W)) u_bank_a (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .sel_addr  (sel_addr),
    .din       (duty_a),
    .wrap      (wrap),
    .pend_flat (pend_a_flat),
    .act_flat  (act_a_flat)
  );

  led_pwm_duty_bank #(.CH(CH_PER_BANK), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W)) u_bank_b (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .sel_addr  (sel_addr),
    .din       (duty_b),
    .wrap      (wrap),
    .pend_flat (pend_b_flat),
    .act_flat  (act_b_flat)
  );

  for (genvar c = 0; c < CH_PER_BANK; c++) begin : g_chan
    led_pwm_channel #(.DUTY_W(DUTY_W), .IDX(c), .STEP(STAGGER_STEP)) u_ch_a (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (cnt),
      .duty      (act_a_flat[c*DUTY_W +: DUTY_W]),
      .force_off (force_off),
      .en        (en_a[c])
    );
    led_pwm_channel #(.DUTY_W(DUTY_W), .IDX(CH_PER_BANK + c), .STEP(STAGGER_STEP)) u_ch_b (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (cnt),
      .duty      (act_b_flat[c*DUTY_W +: DUTY_W]),
      .force_off (force_off),
      .en        (en_b[c])
    );
  end

endmodule

// File: rtl/led_pwm_dual_bank_chk.sv
module led_pwm_dual_bank_chk #(
  parameter int CH     = 8,
  parameter int DUTY_W = 10,
  parameter int ADDR_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 commit,
  input logic [ADDR_W-1:0]    sel_addr,
  input logic [DUTY_W-1:0]    duty_a,
  input logic [DUTY_W-1:0]    duty_b,
  input logic                 force_off,
  input logic                 tick,
  input logic                 wrap,
  input logic [DUTY_W-1:0]    cnt,
  input logic [CH*DUTY_W-1:0] pend_a_flat,
  input logic [CH*DUTY_W-1:0] pend_b_flat,
  input logic [CH*DUTY_W-1:0] act_a_flat,
  input logic [CH*DUTY_W-1:0] act_b_flat,
  input logic [CH-1:0]        en_a,
  input logic [CH-1:0]        en_b
);

  // R8: blanking lands one cycle after the request
  a_r8_force_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (en_a == '0 && en_b == '0));

  // R4: counter steps by exactly one on a tick
  a_r4_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == DUTY_W'($past(cnt) + 1'b1)));

  // R4: counter holds between ticks
  a_r4_hold_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R6: active words move only at the boundary
  a_r6_active_only_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(act_a_flat) && $stable(act_b_flat)));

  // R6: the boundary loads what was staged
  a_r6_wrap_loads_staged: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (act_a_flat == $past(pend_a_flat) && act_b_flat == $past(pend_b_flat)));

  for (genvar c = 0; c < CH; c++) begin : g_slot_chk
    // R1: bank A slot takes the commit value
    a_r1_commit_lands_a: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && sel_addr == ADDR_W'(c)) |=> (pend_a_flat[c*DUTY_W +: DUTY_W] == $past(duty_a)));
    // R2: bank B slot takes its own value
    a_r2_commit_lands_b: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && sel_addr == ADDR_W'(c)) |=> (pend_b_flat[c*DUTY_W +: DUTY_W] == $past(duty_b)));
    // R1: unselected slots keep their staged value
    a_r1_other_slots_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit && sel_addr == ADDR_W'(c)) |=> $stable(pend_a_flat[c*DUTY_W +: DUTY_W]));
  end

endmodule

bind led_pwm_dual_bank led_pwm_dual_bank_chk #(
  .CH(CH_PER_BANK), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .commit      (commit),
  .sel_addr    (sel_addr),
  .duty_a      (duty_a),
  .duty_b      (duty_b),
  .force_off   (force_off),
  .tick        (tick),
  .wrap        (wrap),
  .cnt         (cnt),
  .pend_a_flat (pend_a_flat),
  .pend_b_flat (pend_b_flat),
  .act_a_flat  (act_a_flat),
  .act_b_flat  (act_b_flat),
  .en_a        (en_a),
  .en_b        (en_b)
);

// File: tb/led_pwm_dual_bank_tb_top.sv
`timescale 1ns/1ps
module led_pwm_dual_bank_tb_top;

  localparam int NCH    = 16;
  localparam int PERIOD = 1024;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       commit;
  logic [2:0] sel_addr;
  logic [9:0] duty_a;
  logic [9:0] duty_b;
  logic [3:0] div_code;
  logic       force_off;
  logic [7:0] en_a;
  logic [7:0] en_b;

  int n_checks = 0;
  int n_err    = 0;
  int win_hi [NCH];

  // Reference model state
  int unsigned m_pre;
  int unsigned m_cnt;
  int unsigned m_pend [NCH];
  int unsigned m_act  [NCH];
  logic [15:0] m_en;

  always #2 clk = ~clk;

  led_pwm_dual_bank dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .sel_addr  (sel_addr),
    .duty_a    (duty_a),
    .duty_b    (duty_b),
    .div_code  (div_code),
    .force_off (force_off),
    .en_a      (en_a),
    .en_b      (en_b)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  function automatic int unsigned model_phase(int unsigned count, int g);
    return (count + 64 * g) % PERIOD;
  endfunction

  // Cycle model written from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0;
      m_cnt = 0;
      m_en  = '0;
      for (int i = 0; i < NCH; i++) begin
        m_pend[i] = 0;
        m_act[i]  = 0;
      end
    end else begin
      bit          tk;
      bit          wr;
      logic [15:0] nx;
      tk = (m_pre >= 32'(div_code));
      wr = tk && (m_cnt == PERIOD - 1);
      for (int i = 0; i < NCH; i++)
        nx[i] = !force_off && (model_phase(m_cnt, i) <= m_act[i]);
      m_en = nx;
      if (wr) for (int i = 0; i < NCH; i++) m_act[i] = m_pend[i];
      if (commit) begin
        m_pend[sel_addr]     = 32'(duty_a);
        m_pend[8 + sel_addr] = 32'(duty_b);
      end
      m_pre = tk ? 0 : m_pre + 1;
      if (tk) m_cnt = (m_cnt + 1) % PERIOD;
    end
  end

  // R9: registered outputs track the model every cycle
  always @(negedge clk) begin
    if (rst_n === 1'b1)
      check("R9 lockstep", int'({en_b, en_a}), int'(m_en));
  end

  task automatic do_commit(input int a, input int da, input int db);
    @(negedge clk);
    commit   = 1'b1;
    sel_addr = 3'(a);
    duty_a   = 10'(da);
    duty_b   = 10'(db);
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic count_window(input int n);
    logic [15:0] v;
    for (int i = 0; i < NCH; i++) win_hi[i] = 0;
    repeat (n) begin
      @(negedge clk);
      v = {en_b, en_a};
      for (int i = 0; i < NCH; i++) if (v[i]) win_hi[i]++;
    end
  endtask

  task automatic stagger_scan();
    logic [15:0] prev;
    logic [15:0] cur;
    logic [15:0] rises;
    int t0, t1, t15, maxr, total;
    t0 = 0; t1 = 0; t15 = 0; maxr = 0; total = 0;
    @(negedge clk);
    prev = {en_b, en_a};
    for (int t = 0; t < PERIOD; t++) begin
      @(negedge clk);
      cur   = {en_b, en_a};
      rises = cur & ~prev;
      if ($countones(rises) > maxr) maxr = $countones(rises);
      total += $countones(rises);
      if (rises[0])  t0  = t;
      if (rises[1])  t1  = t;
      if (rises[15]) t15 = t;
      prev = cur;
    end
    check("R5 max simultaneous rises", maxr, 1);
    check("R5 rises per period", total, 16);
    check("R5 ch1 leads ch0 by 64", (t0 - t1 + PERIOD) % PERIOD, 64);
    check("R5 bank B ch7 trails ch0 by 64", (t15 - t0 + PERIOD) % PERIOD, 64);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL R9 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; commit = 1'b0; sel_addr = '0; duty_a = '0; duty_b = '0;
    div_code = '0; force_off = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 outputs off in reset", int'({en_b, en_a}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 only bank A ch0 on after release", int'({en_b, en_a}), 1);

    // R1/R2/R3: one commit writes a slot in each bank
    do_commit(5, 300, 700);
    do_commit(0, 1023, 0);
    repeat (2048) @(negedge clk);
    count_window(PERIOD);
    check("R1 bank A ch5 duty 300", win_hi[5], 301);
    check("R1 bank A ch4 untouched", win_hi[4], 1);
    check("R2 bank B ch5 duty 700", win_hi[13], 701);
    check("R2 bank B ch0 duty 0", win_hi[8], 1);
    check("R3 duty 1023 always on", win_hi[0], 1024);

    // R5: equal duties, spread edges
    for (int a = 0; a < 8; a++) do_commit(a, 511, 511);
    repeat (2048) @(negedge clk);
    stagger_scan();

    // R4: divisor codes 3 and 15
    @(negedge clk); div_code = 4'd3;
    repeat (8192) @(negedge clk);
    count_window(4096);
    check("R4 div 4 on-time", win_hi[0], 2048);
    check("R4 div 4 bank B", win_hi[12], 2048);
    @(negedge clk); div_code = 4'd15;
    repeat (16384) @(negedge clk);
    count_window(16384);
    check("R4 div 16 on-time", win_hi[2], 8192);
    @(negedge clk); div_code = 4'd0;
    repeat (2048) @(negedge clk);

    // R6: mid-period commit waits for the wrap
    do_commit(3, 0, 511);
    repeat (2048) @(negedge clk);
    while (m_cnt != 100) @(negedge clk);
    commit = 1'b1; sel_addr = 3'd3; duty_a = 10'd1023; duty_b = 10'd511;
    @(negedge clk);
    commit = 1'b0;
    count_window(600);
    check("R6 old duty kept mid-period", win_hi[3], 0);
    repeat (1500) @(negedge clk);
    count_window(PERIOD);
    check("R6 new duty after wrap", win_hi[3], 1024);

    // R8: force-off blanks and retains duties
    @(negedge clk); force_off = 1'b1;
    repeat (50) begin
      @(negedge clk);
      check("R8 forced off", int'({en_b, en_a}), 0);
    end
    force_off = 1'b0;
    repeat (2048) @(negedge clk);
    count_window(PERIOD);
    check("R8 duty retained ch0", win_hi[0], 512);
    check("R8 duty retained ch3", win_hi[3], 1024);

    // Random traffic checked against the model (R9 lockstep)
    for (int k = 0; k < 60; k++) begin
      repeat (10 + ($urandom % 300)) @(negedge clk);
      case ($urandom % 6)
        0: div_code = 4'($urandom % 3);
        1: begin
             force_off = 1'b1;
             repeat (1 + ($urandom % 20)) @(negedge clk);
             force_off = 1'b0;
           end
        default: do_commit(int'($urandom % 8), int'($urandom % 1024), int'($urandom % 1024));
      endcase
    end
    repeat (2048) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule